// File: doc/BRIEF.md
# Hybrid Arrival-Order / Rotating Output Scheduler

This block decides which of five input buffers of a mesh router in a spiking-network fabric is served next. The ports are numbered 0 (local), 1 (north), 2 (east), 3 (south) and 4 (west). Each input buffer pulses an event flag for one cycle when a new packet lands in it. The scheduler records that in a per-port pending register and remembers the order in which the ports became pending.

Under light load the scheduler serves ports strictly in arrival order, so idle buffers never cost a cycle. Once four or more ports are waiting, it switches to rotating fairness. In that mode a pointer marks the highest-priority port, and the port just served drops to the lowest priority.

A grant is presented as a one-hot vector, a port index and a valid flag. The grant stays fixed until the downstream logic accepts it. Only the accept retires the port and moves the rotation pointer.

Top module: `spike_sched_arb`

## Requirements
- R1: After reset no port is pending and no grant is shown. The rotation pointer starts at port 0, so the first grant for a full five-port burst goes to port 0.
- R2: An event pulse on an idle port produces a valid grant for that port in the cycle after the clock edge that samples the pulse.
- R3: Only pending ports are granted. Whenever any port is pending a grant is valid, so no cycle is spent on an idle port. With nothing pending `gnt_vld_o` is 0.
- R4: With fewer than four ports pending (light mode), the pending port whose event arrived earliest is granted.
- R5: In light mode, ports whose events arrive in the same cycle are ordered by their distance from the rotation pointer at that moment. The pointer port comes first, then increasing index modulo 5.
- R6: With four or more ports pending (heavy mode), the pending port nearest the rotation pointer is granted, counting upward modulo 5 from the pointer, regardless of arrival order.
- R7: A valid grant that is not accepted stays on the same port in the next cycle, even if new events arrive or the load mode changes.
- R8: An accept while a grant is valid clears that port's pending state and sets the pointer to the granted index plus one modulo 5. An accept with no valid grant has no effect.
- R9: An event on a port that is already pending and is not being accepted is ignored: its place in the arrival order is kept. An event on the port accepted in the same cycle makes it pending again as the newest arrival.
- R10: When valid, `gnt_o` has exactly one bit set, at position `gnt_idx_o`. When not valid, `gnt_o` is all zero and `gnt_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NP (5) | One-cycle new-packet pulse per input buffer, bit p for port p |
| accept_i | input | 1 | Downstream takes the current grant |
| gnt_o | output | NP (5) | One-hot grant |
| gnt_idx_o | output | IDXW (3) | Index of the granted port |
| gnt_vld_o | output | 1 | A grant is presented |

## Verification
The hardest cases to reach from the ports are those where arrival order and rotation order disagree at the light/heavy boundary. Examples are a backlog of exactly four ports whose arrival order starts away from the pointer, or a stale duplicate event that would reshuffle the arrival order if it were not ignored. The stimulus builds such backlogs while an earlier grant is held un-accepted, so events pile up behind a fixed grant. It then releases them one accept at a time. It also re-arms a port in the very cycle it is accepted, and checks that the port rejoins at the back of the order.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    MODE_ARRIVAL = 1'b0,
    MODE_ROTATE  = 1'b1
  } sched_mode_e;

  // distance of a port from the rotation pointer, walking upward modulo n
  function automatic int ring_dist(input int idx, input int base, input int n);
    return (idx >= base) ? (idx - base) : (idx + n - base);
  endfunction

endpackage

// File: rtl/sched_pending.sv
module sched_pending
  import sched_pkg::*;
#(
  parameter int NP   = 5,
  parameter int IDXW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          evt_i,
  input  logic [NP-1:0]          clr_i,
  input  logic [IDXW-1:0]        ptr_i,
  output logic [NP-1:0]          pend_o,
  output logic [NP-1:0][NP-1:0]  older_o
);

  logic [NP-1:0]         pend_q, pend_d;
  logic [NP-1:0]         stay, enter;
  logic [NP-1:0][NP-1:0] older_q, older_d;
  logic                  pend_en, older_en;

  // older[i][j] = 1 means port i became pending before port j
  always_comb begin
    stay     = pend_q & ~clr_i;
    enter    = evt_i & ~stay;
    pend_d   = stay | enter;
    pend_en  = (|evt_i) | (|clr_i);
    older_en = |enter;
    older_d  = older_q;
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        if (i != j) begin
          if (enter[i] && enter[j]) begin
            older_d[i][j] = ring_dist(i, int'(ptr_i), NP) < ring_dist(j, int'(ptr_i), NP);
          end else if (enter[i]) begin
            older_d[i][j] = 1'b0;
          end else if (enter[j]) begin
            older_d[i][j] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else if (older_en) begin
      older_q <= older_d;
    end
  end

  assign pend_o  = pend_q;
  assign older_o = older_q;

endmodule

// File: rtl/sched_select.sv
module sched_select
  import sched_pkg::*;
#(
  parameter int NP       = 5,
  parameter int IDXW     = 3,
  parameter int HEAVY_TH = 4
) (
  input  logic [NP-1:0]          pend_i,
  input  logic [NP-1:0][NP-1:0]  older_i,
  input  logic [IDXW-1:0]        ptr_i,
  output logic [NP-1:0]          pick_oh_o,
  output logic [IDXW-1:0]        pick_idx_o,
  output logic                   pick_vld_o
);

  logic [NP-1:0]   oldest;
  logic [NP-1:0]   rot_oh;
  logic [IDXW-1:0] rot_idx;
  logic            rot_hit;
  sched_mode_e     mode;
  int              pend_cnt;

  // arrival-order winner: pending and older than every other pending port
  for (genvar p = 0; p < NP; p++) begin : g_age
    logic [NP-1:0] beaten;
    always_comb begin
      beaten = '0;
      for (int q = 0; q < NP; q++) begin
        if (q != p) beaten[q] = pend_i[q] & ~older_i[p][q];
      end
    end
    assign oldest[p] = pend_i[p] & ~(|beaten);
  end

  always_comb begin
    pend_cnt = 0;
    for (int p = 0; p < NP; p++) pend_cnt += int'(pend_i[p]);
    mode = (pend_cnt >= HEAVY_TH) ? MODE_ROTATE : MODE_ARRIVAL;
  end

  // rotating winner: first pending port at or after the pointer
  always_comb begin
    rot_idx = '0;
    rot_hit = 1'b0;
    for (int k = NP - 1; k >= 0; k--) begin
      if (pend_i[(int'(ptr_i) + k) % NP]) begin
        rot_idx = IDXW'((int'(ptr_i) + k) % NP);
        rot_hit = 1'b1;
      end
    end
    rot_oh = '0;
    for (int p = 0; p < NP; p++) begin
      if (rot_hit && (rot_idx == IDXW'(p))) rot_oh[p] = 1'b1;
    end
  end

  always_comb begin
    pick_oh_o  = (mode == MODE_ROTATE) ? rot_oh : oldest;
    pick_idx_o = '0;
    for (int p = 0; p < NP; p++) begin
      if (pick_oh_o[p]) pick_idx_o = IDXW'(p);
    end
    pick_vld_o = |pick_oh_o;
  end

endmodule

// File: rtl/sched_hold.sv
module sched_hold #(
  parameter int NP   = 5,
  parameter int IDXW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    pick_oh_i,
  input  logic [IDXW-1:0]  pick_idx_i,
  input  logic             pick_vld_i,
  input  logic             accept_i,
  output logic [NP-1:0]    gnt_oh_o,
  output logic [IDXW-1:0]  gnt_idx_o,
  output logic             gnt_vld_o,
  output logic [NP-1:0]    clr_o,
  output logic [IDXW-1:0]  ptr_o
);

  logic            lock_q, lock_d;
  logic [NP-1:0]   lock_oh_q;
  logic [IDXW-1:0] lock_idx_q;
  logic            cap_en;
  logic [IDXW-1:0] ptr_q, ptr_d;
  logic            ptr_en;
  logic            fire;

  always_comb begin
    gnt_oh_o  = lock_q ? lock_oh_q  : pick_oh_i;
    gnt_idx_o = lock_q ? lock_idx_q : pick_idx_i;
    gnt_vld_o = lock_q | pick_vld_i;
    fire      = gnt_vld_o & accept_i;
    clr_o     = fire ? gnt_oh_o : '0;
    lock_d    = gnt_vld_o & ~accept_i;
    cap_en    = ~lock_q & pick_vld_i;
    ptr_en    = fire;
    ptr_d     = (gnt_idx_o == IDXW'(NP - 1)) ? '0 : gnt_idx_o + IDXW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_oh_q  <= '0;
      lock_idx_q <= '0;
    end else if (cap_en) begin
      lock_oh_q  <= pick_oh_i;
      lock_idx_q <= pick_idx_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/spike_sched_arb.sv
module spike_sched_arb #(
  parameter int NP       = 5,
  parameter int HEAVY_TH = 4,
  localparam int IDXW    = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    evt_i,
  input  logic             accept_i,
  output logic [NP-1:0]    gnt_o,
  output logic [IDXW-1:0]  gnt_idx_o,
  output logic             gnt_vld_o
);

  logic [NP-1:0]         pend_w;
  logic [NP-1:0][NP-1:0] older_w;
  logic [NP-1:0]         clr_w;
  logic [IDXW-1:0]       ptr_w;
  logic [NP-1:0]         pick_oh_w;
  logic [IDXW-1:0]       pick_idx_w;
  logic                  pick_vld_w;

  sched_pending #(.NP(NP), .IDXW(IDXW)) pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_i),
    .clr_i   (clr_w),
    .ptr_i   (ptr_w),
    .pend_o  (pend_w),
    .older_o (older_w)
  );

  sched_select #(.NP(NP), .IDXW(IDXW), .HEAVY_TH(HEAVY_TH)) sel_i (
    .pend_i     (pend_w),
    .older_i    (older_w),
    .ptr_i      (ptr_w),
    .pick_oh_o  (pick_oh_w),
    .pick_idx_o (pick_idx_w),
    .pick_vld_o (pick_vld_w)
  );

  sched_hold #(.NP(NP), .IDXW(IDXW)) hold_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_oh_i  (pick_oh_w),
    .pick_idx_i (pick_idx_w),
    .pick_vld_i (pick_vld_w),
    .accept_i   (accept_i),
    .gnt_oh_o   (gnt_o),
    .gnt_idx_o  (gnt_idx_o),
    .gnt_vld_o  (gnt_vld_o),
    .clr_o      (clr_w),
    .ptr_o      (ptr_w)
  );

endmodule

// File: rtl/sched_arb_chk.sv
module sched_arb_chk #(
  parameter int NP   = 5,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_i,
  input logic [NP-1:0]   gnt_o,
  input logic [IDXW-1:0] gnt_idx_o,
  input logic            gnt_vld_o,
  input logic [NP-1:0]   pend,
  input logic [IDXW-1:0] ptr
);

  // R10: one bit set, at the reported index
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> (($countones(gnt_o) == 1) && gnt_o[gnt_idx_o]));

  // R10: idle outputs are all zero
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld_o |-> ((gnt_o == '0) && (gnt_idx_o == '0)));

  // R3: a grant only lands on a pending port
  p_pend_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld_o |-> ((gnt_o & ~pend) == '0));

  // R3: no idle cycle while work is waiting
  p_no_bubble_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> gnt_vld_o);

  // R7: an unaccepted grant is held
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && !accept_i) |=> (gnt_vld_o && $stable(gnt_o)));

  // R8: pointer moves past the served port
  p_ptr_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld_o && accept_i) |=>
      (ptr == (($past(gnt_idx_o) == IDXW'(NP - 1)) ? '0 : ($past(gnt_idx_o) + IDXW'(1)))));

  // R8: accept without a grant leaves the pointer alone
  p_idle_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld_o && accept_i) |=> $stable(ptr));

endmodule

bind spike_sched_arb sched_arb_chk #(.NP(NP), .IDXW(IDXW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept_i  (accept_i),
  .gnt_o     (gnt_o),
  .gnt_idx_o (gnt_idx_o),
  .gnt_vld_o (gnt_vld_o),
  .pend      (pend_w),
  .ptr       (ptr_w)
);

// File: tb/spike_sched_arb_tb_top.sv
module spike_sched_arb_tb_top;

  logic       clk;
  logic       rst_n;
  logic [4:0] evt_i;
  logic       accept_i;
  logic [4:0] gnt_o;
  logic [2:0] gnt_idx_o;
  logic       gnt_vld_o;

  int tests;
  int fails;

  spike_sched_arb dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .accept_i  (accept_i),
    .gnt_o     (gnt_o),
    .gnt_idx_o (gnt_idx_o),
    .gnt_vld_o (gnt_vld_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {req, evt[4:0], accept, exp_vld, exp_idx}; ports 0 local,1 N,2 E,3 S,4 W
  localparam int NV = 35;
  localparam logic [13:0] VEC [NV] = '{
    {4'd2,  5'b00100, 1'b0, 1'b1, 3'd2},  // R2 first grant
    {4'd7,  5'b00010, 1'b0, 1'b1, 3'd2},  // R7 held
    {4'd4,  5'b10000, 1'b1, 1'b1, 3'd1},  // R4 older port 1 beats pointer-near 4
    {4'd3,  5'b00000, 1'b1, 1'b1, 3'd4},  // R3
    {4'd3,  5'b00000, 1'b1, 1'b0, 3'd0},  // R3 drained
    {4'd5,  5'b01010, 1'b0, 1'b1, 3'd1},  // R5 tie by pointer
    {4'd8,  5'b00000, 1'b1, 1'b1, 3'd3},  // R8
    {4'd7,  5'b00011, 1'b0, 1'b1, 3'd3},  // R7
    {4'd5,  5'b00000, 1'b1, 1'b1, 3'd0},  // R5
    {4'd4,  5'b00000, 1'b1, 1'b1, 3'd1},  // R4
    {4'd3,  5'b00000, 1'b1, 1'b0, 3'd0},  // R3
    {4'd2,  5'b00001, 1'b0, 1'b1, 3'd0},  // R2
    {4'd7,  5'b11110, 1'b0, 1'b1, 3'd0},  // R7 mode change while held
    {4'd6,  5'b00000, 1'b1, 1'b1, 3'd1},  // R6 rotation, not arrival
    {4'd4,  5'b00000, 1'b1, 1'b1, 3'd2},  // R4
    {4'd6,  5'b00011, 1'b1, 1'b1, 3'd3},  // R6 four pending
    {4'd5,  5'b00000, 1'b1, 1'b1, 3'd4},  // R5
    {4'd4,  5'b00000, 1'b1, 1'b1, 3'd0},  // R4
    {4'd8,  5'b00000, 1'b1, 1'b1, 3'd1},  // R8
    {4'd3,  5'b00000, 1'b1, 1'b0, 3'd0},  // R3
    {4'd2,  5'b00001, 1'b0, 1'b1, 3'd0},  // R2
    {4'd7,  5'b01000, 1'b0, 1'b1, 3'd0},  // R7
    {4'd7,  5'b00010, 1'b0, 1'b1, 3'd0},  // R7
    {4'd9,  5'b01000, 1'b0, 1'b1, 3'd0},  // R9 duplicate on port 3
    {4'd9,  5'b00001, 1'b1, 1'b1, 3'd3},  // R9 port 3 kept its age
    {4'd9,  5'b00000, 1'b1, 1'b1, 3'd1},  // R9
    {4'd9,  5'b00000, 1'b1, 1'b1, 3'd0},  // R9 re-armed port 0 served last
    {4'd3,  5'b00000, 1'b1, 1'b0, 3'd0},  // R3
    {4'd8,  5'b00000, 1'b1, 1'b0, 3'd0},  // R8 accept while idle
    {4'd6,  5'b11111, 1'b0, 1'b1, 3'd1},  // R6 pointer still at 1
    {4'd6,  5'b00000, 1'b1, 1'b1, 3'd2},  // R6
    {4'd5,  5'b00000, 1'b1, 1'b1, 3'd3},  // R5
    {4'd4,  5'b00000, 1'b1, 1'b1, 3'd4},  // R4
    {4'd4,  5'b00000, 1'b1, 1'b1, 3'd0},  // R4
    {4'd3,  5'b00000, 1'b1, 1'b0, 3'd0}   // R3
  };

  task automatic check(input int rq, input logic ev, input logic [2:0] ei);
    logic [4:0] eg;
    eg = ev ? (5'b00001 << ei) : 5'b00000;
    tests++;
    if (gnt_vld_o !== ev || gnt_o !== eg || gnt_idx_o !== ei) begin
      fails++;
      $display("FAIL R%0d: vld=%0b gnt=%b idx=%0d expected vld=%0b gnt=%b idx=%0d",
               rq, gnt_vld_o, gnt_o, gnt_idx_o, ev, eg, ei);
    end
  endtask

  task automatic step(input logic [4:0] ev, input logic acc);
    @(negedge clk);
    evt_i    = ev;
    accept_i = acc;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests    = 0;
    fails    = 0;
    rst_n    = 1'b0;
    evt_i    = '0;
    accept_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(1, 1'b0, 3'd0);  // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      step(VEC[n][9:5], VEC[n][4]);
      check(int'(VEC[n][13:10]), VEC[n][3], VEC[n][2:0]);
    end

    // R1: reset in mid-traffic clears pending work and the pointer
    step(5'b00100, 1'b0);
    check(2, 1'b1, 3'd2);
    @(negedge clk);
    evt_i = '0;
    rst_n = 1'b0;
    #2;
    check(1, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(5'b11111, 1'b0);
    check(1, 1'b1, 3'd0);  // R1 pointer back at port 0
    step(5'b00000, 1'b1);
    check(6, 1'b1, 3'd1);
    step(5'b00000, 1'b1);
    check(4, 1'b1, 3'd2);
    step(5'b00000, 1'b1);
    check(4, 1'b1, 3'd3);
    step(5'b00000, 1'b1);
    check(4, 1'b1, 3'd4);
    step(5'b00000, 1'b1);
    check(3, 1'b0, 3'd0);
    step(5'b00000, 1'b0);
    check(10, 1'b0, 3'd0);  // R10 idle outputs

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule